// File: doc/BRIEF.md
# RTC Update Sequencer and Interrupt Status

This block sequences the once-per-second time update of a real-time clock and keeps its interrupt status. A one-second tick starts an update window. An update-in-progress bit rises first and holds for a fixed lead time, measured in 32.768 kHz reference enables. The update phase follows. At its end the block sends a one-cycle pulse to the time counters, and the update-in-progress bit falls on that same edge.

Three event sources set sticky flags: periodic and alarm events from neighbouring logic, and the update-ended event raised here. The flags are visible on a small register bus. A read of the status register returns its value and clears it. A control register holds a freeze bit, which blocks and aborts updates while software sets the time, and the three interrupt enables. An active-low interrupt line follows the summary bit of the status register.

Top module: `rtc_update_irq`

## Requirements
- R1: After reset uip=0, upd_done=0 and irq_n=1. Registers at select 1 (control) and select 2 (status) read 0x00.
- R2: With the freeze bit clear and no window open, a sec_tick opens a window: uip is 1 from the next cycle. Register select 0 returns uip in bit 7 and 0 in bits 6:0.
- R3: uip stays high for exactly LEAD_TICKS+UPD_TICKS reference enables (default 8+65). It falls on the edge of the last one, and upd_done is high for that single cycle.
- R4: Each event sets its flag in the status register whatever the enables hold: bit 6 by periodic_evt, bit 5 by alarm_evt, bit 4 by the update end. A flag stays set until the status register is read.
- R5: Status bit 7 is 1 exactly when some flag is set and its enable is 1 (control bit 6 periodic, bit 5 alarm, bit 4 update-ended). irq_n is the inverse of status bit 7.
- R6: A read at select 2 returns the current status and clears every flag on that edge, except a flag whose event arrives in the same cycle. That flag is set after the read.
- R7: While control bit 7 (freeze) is 1, a sec_tick opens no window and is lost. Setting freeze during a window closes it without upd_done and without an update-ended flag.
- R8: A sec_tick that arrives while a window is open is ignored and does not lengthen the window.
- R9: Select 3 always reads 0x80. Writes at selects 0, 2 and 3 change nothing. The control register at select 1 reads back all 8 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| sec_tick | input | 1 | One-cycle pulse once per second |
| periodic_evt | input | 1 | Periodic event pulse |
| alarm_evt | input | 1 | Alarm match pulse |
| reg_sel | input | 2 | Register select: 0 update status, 1 control, 2 flags, 3 validity |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (a read at select 2 clears the flags) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| uip | output | 1 | Update in progress |
| upd_done | output | 1 | One-cycle pulse to the time counters at update end |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A phase counter that is off by one shows at the ports as uip falling one reference enable early or late. The bench counts the enables in every window, so the error appears at the end of the first update. A freeze bit that fails to reach the sequencer shows as a window opening, or upd_done pulsing, within one cycle of the tick or of the abort. A wrong flag or enable slice shows as a wrong status byte or irq_n level. The sweep of all 64 flag and enable combinations reads that byte back right after the events.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_UPD  = 2'd2
  } upd_state_e;

  localparam logic [1:0] SEL_UPD  = 2'd0;
  localparam logic [1:0] SEL_CTL  = 2'd1;
  localparam logic [1:0] SEL_FLG  = 2'd2;
  localparam logic [1:0] SEL_VAL  = 2'd3;

  localparam int NUM_SRC   = 3;
  localparam int CTL_FRZ   = 7;
  localparam int EN_LSB    = 4;
  localparam logic [7:0] VALID_BYTE = 8'h80;

endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq
  import rtc_upd_pkg::*;
#(
  parameter int LEAD_TICKS = 8,
  parameter int UPD_TICKS  = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_en,
  input  logic sec_tick,
  input  logic freeze,
  output logic uip,
  output logic upd_done,
  output logic uf_evt
);
  localparam int MAX_T = (LEAD_TICKS > UPD_TICKS) ? LEAD_TICKS : UPD_TICKS;
  localparam int CNT_W = (MAX_T > 1) ? $clog2(MAX_T) : 1;
  localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEAD_TICKS - 1);
  localparam logic [CNT_W-1:0] UPD_LAST  = CNT_W'(UPD_TICKS - 1);

  upd_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sec_tick && !freeze) begin
          state_d = ST_LEAD;
          cnt_d   = '0;
        end
      end
      ST_LEAD: begin
        if (freeze) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (ref_en) begin
          if (cnt_q == LEAD_LAST) begin
            state_d = ST_UPD;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_UPD: begin
        if (freeze) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (ref_en) begin
          if (cnt_q == UPD_LAST) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            done_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign uip      = (state_q != ST_IDLE);
  assign upd_done = done_q;
  assign uf_evt   = done_d;
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_upd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic [NUM_SRC-1:0] en,
  input  logic               clr,
  output logic [NUM_SRC-1:0] flags,
  output logic               irqf
);
  logic [NUM_SRC-1:0] flag_q, flag_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_comb flag_d[i] = evt[i] | (flag_q[i] & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags = flag_q;
  assign irqf  = |(flag_q & en);
endmodule

// File: rtl/rtc_ctl_regs.sv
module rtc_ctl_regs
  import rtc_upd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         reg_sel,
  input  logic               reg_wr,
  input  logic [7:0]         reg_wdata,
  input  logic               uip,
  input  logic [NUM_SRC-1:0] flags,
  input  logic               irqf,
  output logic               freeze,
  output logic [NUM_SRC-1:0] en,
  output logic [7:0]         reg_rdata
);
  logic [7:0] ctl_q, ctl_d;
  logic       ctl_we;

  assign ctl_we = reg_wr && (reg_sel == SEL_CTL);

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we) ctl_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= 8'h00;
    else        ctl_q <= ctl_d;
  end

  assign freeze = ctl_q[CTL_FRZ];
  assign en     = ctl_q[EN_LSB +: NUM_SRC];

  always_comb begin
    reg_rdata = 8'h00;
    unique case (reg_sel)
      SEL_UPD: reg_rdata = {uip, 7'd0};
      SEL_CTL: reg_rdata = ctl_q;
      SEL_FLG: reg_rdata = {irqf, flags, 4'd0};
      SEL_VAL: reg_rdata = VALID_BYTE;
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_update_irq.sv
module rtc_update_irq
  import rtc_upd_pkg::*;
#(
  parameter int LEAD_TICKS = 8,
  parameter int UPD_TICKS  = 65
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_en,
  input  logic       sec_tick,
  input  logic       periodic_evt,
  input  logic       alarm_evt,
  input  logic [1:0] reg_sel,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       uip,
  output logic       upd_done,
  output logic       irq_n
);
  logic               rst_n_s;
  logic               freeze;
  logic               uf_evt;
  logic               irqf;
  logic               flg_clr;
  logic [NUM_SRC-1:0] en_vec;
  logic [NUM_SRC-1:0] flag_vec;
  logic [NUM_SRC-1:0] evt_vec;

  rtc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  rtc_upd_seq #(
    .LEAD_TICKS (LEAD_TICKS),
    .UPD_TICKS  (UPD_TICKS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ref_en   (ref_en),
    .sec_tick (sec_tick),
    .freeze   (freeze),
    .uip      (uip),
    .upd_done (upd_done),
    .uf_evt   (uf_evt)
  );

  assign evt_vec = {periodic_evt, alarm_evt, uf_evt};
  assign flg_clr = reg_rd && (reg_sel == SEL_FLG);

  rtc_irq_flags u_flags (
    .clk   (clk),
    .rst_n (rst_n_s),
    .evt   (evt_vec),
    .en    (en_vec),
    .clr   (flg_clr),
    .flags (flag_vec),
    .irqf  (irqf)
  );

  rtc_ctl_regs u_ctl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .uip       (uip),
    .flags     (flag_vec),
    .irqf      (irqf),
    .freeze    (freeze),
    .en        (en_vec),
    .reg_rdata (reg_rdata)
  );

  assign irq_n = ~irqf;
endmodule

// File: rtl/rtc_update_irq_chk.sv
module rtc_update_irq_chk (
  input logic       clk,
  input logic       rst_n_s,
  input logic       sec_tick,
  input logic       periodic_evt,
  input logic       alarm_evt,
  input logic [1:0] reg_sel,
  input logic       reg_rd,
  input logic [7:0] reg_rdata,
  input logic       uip,
  input logic       upd_done,
  input logic       irq_n,
  input logic       freeze,
  input logic       uf_evt,
  input logic [2:0] flag_vec
);
  AST_DONE_ENDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    upd_done |-> (!uip && $past(uip)));                                // R3
  AST_WINDOW_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(uip) |-> $past(sec_tick));                                   // R2
  AST_FREEZE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n_s)
    freeze |=> !upd_done);                                             // R7
  AST_FREEZE_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n_s)
    (freeze && !uip) |=> !uip);                                        // R7
  AST_ALARM_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n_s)
    alarm_evt |=> flag_vec[1]);                                        // R4
  AST_PERIODIC_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n_s)
    periodic_evt |=> flag_vec[2]);                                     // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_rd && reg_sel == 2'd2 && !periodic_evt && !alarm_evt && !uf_evt)
      |=> (flag_vec == 3'b000));                                       // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n_s)
    !irq_n |-> (flag_vec != 3'b000));                                  // R5
  AST_VALID_CONST: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_sel == 2'd3) |-> (reg_rdata == 8'h80));                       // R9
endmodule

bind rtc_update_irq rtc_update_irq_chk u_chk (
  .clk          (clk),
  .rst_n_s      (rst_n_s),
  .sec_tick     (sec_tick),
  .periodic_evt (periodic_evt),
  .alarm_evt    (alarm_evt),
  .reg_sel      (reg_sel),
  .reg_rd       (reg_rd),
  .reg_rdata    (reg_rdata),
  .uip          (uip),
  .upd_done     (upd_done),
  .irq_n        (irq_n),
  .freeze       (freeze),
  .uf_evt       (uf_evt),
  .flag_vec     (flag_vec)
);

// File: tb/tb_rtc_update_irq.sv
module tb_rtc_update_irq;
  localparam int LEAD = 8;
  localparam int UPD  = 65;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_en, sec_tick, periodic_evt, alarm_evt;
  logic [1:0] reg_sel;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       uip, upd_done, irq_n;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rtc_update_irq #(.LEAD_TICKS(LEAD), .UPD_TICKS(UPD)) dut (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .sec_tick(sec_tick),
    .periodic_evt(periodic_evt), .alarm_evt(alarm_evt),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .uip(uip), .upd_done(upd_done), .irq_n(irq_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    reg_sel = sel;
    reg_rd  = 1'b1;
    #0.5;
    d = reg_rdata;
    cyc();
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    reg_sel   = sel;
    reg_wdata = d;
    reg_wr    = 1'b1;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic ref_pulse();
    ref_en = 1'b1;
    cyc();
    ref_en = 1'b0;
    cyc();
  endtask

  task automatic tick();
    sec_tick = 1'b1;
    cyc();
    sec_tick = 1'b0;
  endtask

  // Pulses the reference until uip falls; returns the pulse count and whether
  // upd_done was seen in the cycle uip fell.
  task automatic run_window(output int n, output bit done_seen, input int tick_at);
    n = 0;
    done_seen = 1'b0;
    while (uip && n < 200) begin
      if (n == tick_at) sec_tick = 1'b1;
      ref_en = 1'b1;
      cyc();
      ref_en = 1'b0;
      sec_tick = 1'b0;
      n++;
      if (!uip) done_seen = upd_done;
      cyc();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R3 watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    bit ds;
    rst_n = 1'b0; ref_en = 0; sec_tick = 0; periodic_evt = 0; alarm_evt = 0;
    reg_sel = 0; reg_wr = 0; reg_rd = 0; reg_wdata = 0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (3) cyc();

    // R1 reset state
    chk("R1 uip", uip, 0);
    chk("R1 upd_done", upd_done, 0);
    chk("R1 irq_n", irq_n, 1);
    rd(2'd1, d); chk("R1 control", d, 8'h00);
    rd(2'd2, d); chk("R1 status", d, 8'h00);

    // R2 / R3 basic window
    tick();
    chk("R2 uip rises", uip, 1);
    reg_sel = 2'd0; #0.5; chk("R2 select0 bit7", reg_rdata, 8'h80);
    run_window(n, ds, -1);
    chk("R3 enables in window", n, LEAD + UPD);
    chk("R3 done at fall", ds, 1);
    chk("R3 done one cycle", upd_done, 0);
    reg_sel = 2'd0; #0.5; chk("R2 select0 idle", reg_rdata, 8'h00);
    rd(2'd2, d); chk("R4 update flag no enable", d, 8'h10);

    // R8 tick inside window ignored
    tick();
    run_window(n, ds, 20);
    chk("R8 window not extended", n, LEAD + UPD);
    chk("R8 no second window", uip, 0);
    rd(2'd2, d);

    // R7 freeze blocks ticks
    wr(2'd1, 8'h80);
    tick();
    chk("R7 no window under freeze", uip, 0);
    repeat (5) ref_pulse();
    wr(2'd1, 8'h00);
    chk("R7 tick dropped", uip, 0);
    rd(2'd2, d); chk("R7 no update flag", d, 8'h00);

    // R7 abort mid-window
    wr(2'd1, 8'h10);
    tick();
    repeat (LEAD + 3) ref_pulse();
    chk("R7 window open", uip, 1);
    wr(2'd1, 8'h90);
    chk("R7 done not raised", upd_done, 0);
    cyc();
    chk("R7 window closed", uip, 0);
    chk("R7 done after abort", upd_done, 0);
    repeat (UPD) ref_pulse();
    chk("R7 irq_n after abort", irq_n, 1);
    wr(2'd1, 8'h00);
    rd(2'd2, d); chk("R7 abort no flag", d, 8'h00);

    // R4/R5/R6 sweep of flags x enables
    for (int en = 0; en < 8; en++) begin
      for (int fl = 0; fl < 8; fl++) begin
        logic irqf_e;
        wr(2'd1, {1'b0, en[2:0], 4'h0});
        if (fl[2] || fl[1]) begin
          periodic_evt = fl[2];
          alarm_evt    = fl[1];
          cyc();
          periodic_evt = 0;
          alarm_evt    = 0;
        end
        if (fl[0]) begin
          tick();
          run_window(n, ds, -1);
        end
        irqf_e = |(fl[2:0] & en[2:0]);
        chk("R5 irq_n level", irq_n, !irqf_e);
        rd(2'd2, d);
        chk("R4 R5 status byte", d, {irqf_e, fl[2:0], 4'h0});
        chk("R6 irq_n after read", irq_n, 1);
        rd(2'd2, d);
        chk("R6 cleared", d, 8'h00);
      end
    end

    // R6 event in same cycle as clearing read
    wr(2'd1, 8'h00);
    periodic_evt = 1; cyc(); periodic_evt = 0;
    alarm_evt = 1;
    rd(2'd2, d);
    alarm_evt = 0;
    chk("R6 read returns old", d, 8'h40);
    rd(2'd2, d);
    chk("R6 coincident flag kept", d, 8'h20);

    // R9 ignored writes and constant validity byte
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'h00);
    rd(2'd0, d); chk("R9 select0 write ignored", d, 8'h00);
    rd(2'd2, d); chk("R9 select2 write ignored", d, 8'h00);
    rd(2'd3, d); chk("R9 validity byte", d, 8'h80);
    wr(2'd1, 8'h5A);
    rd(2'd1, d); chk("R9 control readback", d, 8'h5A);
    wr(2'd1, 8'h00);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule